// File: doc/BRIEF.md
# Burst Read Sequencer with Suspend

This block fetches a run of 16-bit words from a small behavioural word array in a fixed 32-word burst. A low pulse on `load_n` captures a start address and clears a 5-bit burst offset. Each later rising clock edge with both `adv_n` and `oe_n` low moves the offset on by one and fetches the next word. Only the low five address bits take part in the count, so the burst wraps inside its aligned 32-word window and comes back to the start word after the 32nd.

The fetched word sits in a holding register. When `adv_n` is high the burst stops and the word stays put. `rd_drive` falls whenever `oe_n` is high, which stands in for a high-impedance bus. With `oe_n` low and `adv_n` high, the same held word is presented again. `eob_n` marks the last word of the burst. A write port fills the array. `rst_n` is asserted asynchronously and released through a two-stage synchronizer. While reset is held, and until it has been released internally, every access is ignored.

Top module: `brs_burst_seq`

## Requirements
- R1: A clock edge with `load_n` low captures `start_addr`, sets the offset to 0 and starts a burst. From then on the held word is the array word at `start_addr` and `eob_n` is high.
- R2: A clock edge with an active burst, `load_n` high, `adv_n` low and `oe_n` low adds one to the offset, modulo 32. The held word becomes the array word at the start address with its low 5 bits replaced by (start low bits + offset) mod 32. The higher address bits stay fixed.
- R3: An advance taken at offset 31 returns the offset to 0, and the word at the start address is held again.
- R4: `eob_n` is low exactly when a burst is active and its offset is 31.
- R5: `rd_drive` is high exactly when a burst is active and `oe_n` is low. `rd_data` equals the held word while `rd_drive` is high and is 0 otherwise.
- R6: An edge with `adv_n` high leaves the offset and the held word unchanged, whatever `oe_n` does. Lowering `oe_n` alone presents the same word again. Lowering both resumes with the next word.
- R7: An edge with `adv_n` low but `oe_n` high does not advance the burst.
- R8: Before the first load, and after any reset, no burst is active: `rd_drive` is low, `eob_n` is high, and advance requests have no effect.
- R9: A load during an active or suspended burst restarts at the new address. A load has priority over an advance on the same edge.
- R10: `rst_n` low at once drops `rd_drive`, raises `eob_n` and ends the burst. Loads and writes are ignored while it is low and for the first two clock edges after it rises.
- R11: A clock edge with `wr_en` high stores `wr_data` at `wr_addr`. The held word was copied at fetch time, so a write to its address does not change what is presented. A read and a write to the same address on one edge return the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_n | input | 1 | Active-low strobe that loads the start address |
| start_addr | input | ADDR_W | Burst start address |
| adv_n | input | 1 | Active-low burst advance |
| oe_n | input | 1 | Active-low output enable |
| wr_en | input | 1 | Array write enable |
| wr_addr | input | ADDR_W | Array write address |
| wr_data | input | DATA_W | Array write data |
| rd_data | output | DATA_W | Presented word, 0 when not driven |
| rd_drive | output | 1 | High when `rd_data` is driven; low stands for high impedance |
| eob_n | output | 1 | Active-low end-of-burst indicator |

## Verification
A wrong offset shows up as a wrong word at the next driven cycle. It also moves the `eob_n` pulse away from the 32nd word, so a counter that skips or sticks is caught within one burst period at most. A wrong active flag changes `rd_drive` in the same cycle that `oe_n` is low. Corruption of the held word during a suspend only appears when `oe_n` is lowered again, so the bench suspends with a write to the held address and then re-enables output. The reference model is compared against the ports one nanosecond after every clock edge, so any divergence is reported in the cycle it first appears.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic {
    BRS_IDLE = 1'b0,
    BRS_RUN  = 1'b1
  } brs_state_e;

  localparam int unsigned BRS_SYNC_STAGES = 2;
endpackage

// File: rtl/brs_rst_sync.sv
module brs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i_n
);
  import brs_pkg::*;

  logic [BRS_SYNC_STAGES-1:0] sync_q;
  logic [BRS_SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[BRS_SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_i_n = sync_q[BRS_SYNC_STAGES-1];
endmodule

// File: rtl/brs_word_array.sv
module brs_word_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];
  logic              wr_fire;

  assign wr_fire = wr_ok & wr_en;

  always_ff @(posedge clk) begin
    if (wr_fire) cell_q[wr_addr] <= wr_data;
  end

  assign rd_word = cell_q[rd_addr];
endmodule

// File: rtl/brs_burst_ctrl.sv
module brs_burst_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_i_n,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] start_addr,
  output brs_pkg::brs_state_e state,
  output logic [OFF_W-1:0]  off,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] fetch_addr
);
  import brs_pkg::*;

  brs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [OFF_W-1:0]  lo_sum;
  logic              do_load, do_step;

  assign do_load = ~load_n;
  assign do_step = (state_q == BRS_RUN) & ~adv_n & ~oe_n;

  always_comb begin
    state_d  = state_q;
    base_d   = base_q;
    off_d    = off_q;
    fetch_en = 1'b0;
    if (do_load) begin
      state_d  = BRS_RUN;
      base_d   = start_addr;
      off_d    = '0;
      fetch_en = 1'b1;
    end else if (do_step) begin
      off_d    = off_q + 1'b1;
      fetch_en = 1'b1;
    end
  end

  // Low bits wrap within the aligned window; high bits come from the base.
  assign lo_sum = base_d[OFF_W-1:0] + off_d;

  generate
    if (ADDR_W > OFF_W) begin : g_hi
      assign fetch_addr = {base_d[ADDR_W-1:OFF_W], lo_sum};
    end else begin : g_lo
      assign fetch_addr = lo_sum;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= BRS_IDLE;
      base_q  <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      off_q   <= off_d;
    end
  end

  assign state = state_q;
  assign off   = off_q;
endmodule

// File: rtl/brs_out_stage.sv
module brs_out_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_i_n,
  input  brs_pkg::brs_state_e state,
  input  logic [OFF_W-1:0]  off,
  input  logic              oe_n,
  input  logic              fetch_en,
  input  logic [DATA_W-1:0] fetch_word,
  output logic [DATA_W-1:0] held_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              eob_n
);
  import brs_pkg::*;

  logic [DATA_W-1:0] word_q, word_d;
  logic              run;

  assign run = (state == BRS_RUN);

  always_comb begin
    word_d = word_q;
    if (fetch_en) word_d = fetch_word;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) word_q <= '0;
    else          word_q <= word_d;
  end

  assign held_word = word_q;
  assign rd_drive  = run & ~oe_n;
  assign rd_data   = rd_drive ? word_q : '0;
  assign eob_n     = ~(run & (&off));
endmodule

// File: rtl/brs_burst_seq.sv
module brs_burst_seq #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              adv_n,
  input  logic              oe_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              eob_n
);
  import brs_pkg::*;

  logic              rst_i_n;
  brs_state_e        state;
  logic [OFF_W-1:0]  off;
  logic              fetch_en;
  logic [ADDR_W-1:0] fetch_addr;
  logic [DATA_W-1:0] fetch_word;
  logic [DATA_W-1:0] held_word;

  brs_rst_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_i_n (rst_i_n)
  );

  brs_burst_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst_i_n    (rst_i_n),
    .load_n     (load_n),
    .adv_n      (adv_n),
    .oe_n       (oe_n),
    .start_addr (start_addr),
    .state      (state),
    .off        (off),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr)
  );

  brs_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .wr_ok   (rst_i_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (fetch_addr),
    .rd_word (fetch_word)
  );

  brs_out_stage #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_out (
    .clk        (clk),
    .rst_i_n    (rst_i_n),
    .state      (state),
    .off        (off),
    .oe_n       (oe_n),
    .fetch_en   (fetch_en),
    .fetch_word (fetch_word),
    .held_word  (held_word),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive),
    .eob_n      (eob_n)
  );
endmodule

// File: rtl/brs_burst_seq_chk.sv
module brs_burst_seq_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_i_n,
  input logic              load_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              run,
  input logic [OFF_W-1:0]  off,
  input logic [DATA_W-1:0] held_word,
  input logic              rd_drive,
  input logic              eob_n
);
  // R1: a load restarts the count from zero
  p_load_clears_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !load_n |=> (run && off == '0 && eob_n));

  // R2: one step per advance edge
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run && load_n && !adv_n && !oe_n) |=> (off == $past(off) + 1'b1));

  // R3: the last offset wraps to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run && load_n && !adv_n && !oe_n && (&off)) |=> (off == '0));

  // R5: output enable high never drives the bus
  p_oe_blocks_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    oe_n |-> !rd_drive);

  // R6: suspend keeps both offset and held word
  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (run && load_n && adv_n) |=> ($stable(off) && $stable(held_word)));

  // R7: advance without output enable does not count
  p_no_step_oe_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (load_n && oe_n) |=> $stable(off));

  // R10: during external reset nothing is driven and no end mark shows
  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!rd_drive && eob_n));
endmodule

bind brs_burst_seq brs_burst_seq_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_i_n   (rst_i_n),
  .load_n    (load_n),
  .adv_n     (adv_n),
  .oe_n      (oe_n),
  .run       (state == brs_pkg::BRS_RUN),
  .off       (off),
  .held_word (held_word),
  .rd_drive  (rd_drive),
  .eob_n     (eob_n)
);

// File: tb/brs_burst_seq_tb.sv
`timescale 1ns/1ps
module brs_burst_seq_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_n = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              adv_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_drive;
  logic              eob_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  brs_burst_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .start_addr (start_addr),
    .adv_n      (adv_n),
    .oe_n       (oe_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive),
    .eob_n      (eob_n)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503) ^ 23130);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [15:0] m_mem [DEPTH];
  int  m_ready_cnt = 0;
  bit  m_act = 0;
  int  m_base = 0;
  int  m_off = 0;
  logic [15:0] m_word = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ready_cnt = 0;
      m_act = 0;
      m_off = 0;
    end else begin
      if (m_ready_cnt >= 2) begin
        if (!load_n) begin
          m_base = int'(start_addr);
          m_off  = 0;
          m_act  = 1;
          m_word = m_mem[m_base];
        end else if (m_act && !adv_n && !oe_n) begin
          m_off  = (m_off + 1) % 32;
          m_word = m_mem[(m_base & ~31) | ((m_base + m_off) & 31)];
        end
        if (wr_en) m_mem[int'(wr_addr)] = wr_data;
      end
      if (m_ready_cnt < 2) m_ready_cnt++;
    end
  end

  always @(posedge clk) begin
    #1;
    chk("R5 drive", {31'd0, rd_drive}, {31'd0, m_act && !oe_n});
    chk("R4 eob", {31'd0, eob_n}, {31'd0, !(m_act && m_off == 31)});
    chk("R2 data", {16'd0, rd_data}, {16'd0, (m_act && !oe_n) ? m_word : 16'd0});
  end

  task automatic apply(logic l, logic a, logic o);
    load_n = l; adv_n = a; oe_n = o;
    @(posedge clk); #2;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    chk("R10 reset drive", {31'd0, rd_drive}, 32'd0);
    chk("R10 reset eob", {31'd0, eob_n}, 32'd1);
    rst_n = 1'b1;
    repeat (3) apply(1, 1, 1);

    // Fill the array
    for (int a = 0; a < DEPTH; a++) begin
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = pat(a);
      @(posedge clk); #2;
    end
    wr_en = 1'b0;

    // R8: advance before any load
    apply(1, 0, 0);
    apply(1, 0, 0);
    chk("R8 idle drive", {31'd0, rd_drive}, 32'd0);
    chk("R8 idle eob", {31'd0, eob_n}, 32'd1);

    // R1: load 0x3C
    start_addr = 8'h3C;
    apply(0, 1, 0);
    chk("R1 start word", {16'd0, rd_data}, {16'd0, pat('h3C)});
    chk("R1 eob high", {31'd0, eob_n}, 32'd1);

    // R2: four advances wrap low bits to 0x20
    for (int k = 0; k < 4; k++) apply(1, 0, 0);
    chk("R2 window wrap", {16'd0, rd_data}, {16'd0, pat('h20)});
    for (int k = 0; k < 27; k++) apply(1, 0, 0);
    chk("R4 last word", {16'd0, rd_data}, {16'd0, pat('h3B)});
    chk("R4 eob low", {31'd0, eob_n}, 32'd0);
    apply(1, 0, 0);
    chk("R3 back to start", {16'd0, rd_data}, {16'd0, pat('h3C)});
    chk("R3 eob high", {31'd0, eob_n}, 32'd1);

    // R6 / R7 suspend and resume
    apply(1, 0, 0);
    apply(1, 0, 0);
    chk("R6 pre-suspend", {16'd0, rd_data}, {16'd0, pat('h3E)});
    apply(1, 1, 1);
    chk("R5 hiz drive", {31'd0, rd_drive}, 32'd0);
    chk("R5 hiz data", {16'd0, rd_data}, 32'd0);
    wr_en = 1'b1; wr_addr = 8'h3E; wr_data = 16'h1234;
    apply(1, 1, 1);
    wr_en = 1'b0;
    apply(1, 1, 0);
    chk("R11 held word kept", {16'd0, rd_data}, {16'd0, pat('h3E)});
    apply(1, 1, 0);
    chk("R6 re-present", {16'd0, rd_data}, {16'd0, pat('h3E)});
    apply(1, 0, 1);
    chk("R7 no drive", {31'd0, rd_drive}, 32'd0);
    apply(1, 1, 0);
    chk("R7 no advance", {16'd0, rd_data}, {16'd0, pat('h3E)});
    apply(1, 0, 0);
    chk("R6 resume", {16'd0, rd_data}, {16'd0, pat('h3F)});

    // R9: reload with advance on same edge
    start_addr = 8'h81;
    apply(0, 0, 0);
    chk("R9 reload", {16'd0, rd_data}, {16'd0, pat('h81)});
    for (int k = 0; k < 30; k++) apply(1, 0, 0);
    chk("R2 high bits fixed", {16'd0, rd_data}, {16'd0, pat('h9F)});
    apply(1, 0, 0);
    chk("R4 eob at 31", {31'd0, eob_n}, 32'd0);
    chk("R2 wrap low", {16'd0, rd_data}, {16'd0, pat('h80)});

    // R11: reload written address
    start_addr = 8'h3E;
    apply(0, 1, 0);
    chk("R11 new contents", {16'd0, rd_data}, {16'd0, 16'h1234});

    // R10: reset mid-burst, write and load ignored
    apply(1, 0, 0);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R10 async drop", {31'd0, rd_drive}, 32'd0);
    chk("R10 async eob", {31'd0, eob_n}, 32'd1);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = 8'h05; wr_data = 16'hDEAD; start_addr = 8'h05;
    apply(0, 0, 0);
    rst_n = 1'b1;
    apply(0, 0, 0);
    chk("R10 load ignored", {31'd0, rd_drive}, 32'd0);
    wr_en = 1'b0;
    apply(1, 1, 0);
    apply(0, 1, 0);
    chk("R10 write ignored", {16'd0, rd_data}, {16'd0, pat('h05)});
    apply(1, 1, 1);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule